// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Core

This block is the digital heart of a 1 Kbit serial non-volatile memory. A host talks to it over a three-wire serial link: a select line, a serial clock, and a data input. A fourth wire carries data back. An organization pin chooses between 128 byte locations and 64 sixteen-bit words. Commands arrive most-significant bit first and are sampled on rising edges of the serial clock. Each command is a start bit, a two-bit opcode and an address field. The core decodes the command and performs one of these actions:

- streams data back;
- collects data for storage;
- changes its write-enable latch.

Programming commands take effect only while the latch is set. A programming command starts a self-timed cycle when the select line falls. The cycle lasts a parameterized number of system clocks. While it runs, the core ignores serial traffic. If the host raises select during or just after the cycle, the data-out line shows ready/busy. The storage array is a register file. All serial inputs pass through two-flop synchronizers into the system clock domain. The output driver is modelled as a data bit plus an output enable.

Top module: `mw_eeprom_core`

## Requirements
- R1: After reset the write-enable latch is clear, no programming cycle is running, and `dout_oe` is low, including while `cs` is high with no command received.
- R2: With `cs` high, zeros before the first 1 on `din` are ignored. That first 1 is the start bit. It is followed by a 2-bit opcode, then 7 address bits when `org` is low or 6 when `org` is high, all MSB first. Opcodes: 10 read, 01 write, 11 erase. Opcode 00 uses the top two address bits: 11 enable, 00 disable, 01 fill-all, 10 erase-all.
- R3: `org` high selects 16-bit words, `org` low selects bytes. Word n occupies byte 2n (bits 7:0) and byte 2n+1 (bits 15:8).
- R4: On a read, the data output becomes enabled at the serial-clock rise that samples the last address bit, and shows a 0 dummy bit there. Each later rise presents the next data bit, MSB first.
- R5: When a read has shifted out the last bit of a location, it continues with the next higher address. From the highest address (127 bytes / 63 words) it wraps to 0, for as long as `cs` stays high.
- R6: The enable command sets the write-enable latch and the disable command clears it. A write, erase, fill-all or erase-all issued while the latch is clear leaves the array unchanged.
- R7: A write stores the data bits received between the address and the fall of `cs`. If more than 8 (byte) or 16 (word) bits arrive, the last 8 or 16 are stored.
- R8: Erase sets the addressed location to all ones. Erase-all sets every location to all ones.
- R9: Fill-all stores its 8- or 16-bit data pattern in every location.
- R10: A programming command starts its cycle when `cs` falls and stays busy for `PROG_CYCLES` clocks. If `cs` is high during the cycle, `dout` is driven 0 while busy and 1 once done.
- R11: The shown status is cleared by a serial-clock rise with `din` high, which also acts as the next start bit. It is also cleared if the cycle finishes while `cs` is low. `dout_oe` is low whenever `cs` is low.
- R12: Serial-clock edges received while a programming cycle runs are ignored. A command sent during the cycle has no effect.
- R13: Lowering `cs` in the middle of a command discards it and returns the core to standby, with no effect on the latch or the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data into the core |
| org | input | 1 | Organization: 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data or ready/busy status |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The bench keeps the default 7-bit byte address, which gives a 128-byte array. With that size, both wrap points (byte 127 to 0 and word 63 to 0) can be read in a few dozen serial clocks. `PROG_CYCLES` is set to 400. That is long enough that a complete 10-bit command fits inside one programming cycle, so the ignore-while-busy rule and the busy status level can both be observed. It is short enough that a dozen programming cycles stay well within the run length.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_DATA = 3'd2,
        ST_HOLD = 3'd3,
        ST_READ = 3'd4
    } mw_state_e;

    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,
        PK_WRITE = 3'd1,
        PK_WRALL = 3'd2,
        PK_ERASE = 3'd3,
        PK_ERAL  = 3'd4
    } mw_prog_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_WDS   = 2'b00;
    localparam logic [1:0] SUB_WRALL = 2'b01;
    localparam logic [1:0] SUB_ERAL  = 2'b10;
    localparam logic [1:0] SUB_WEN   = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int ABITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic [ABITS-1:0] rd_addr,
    output logic [15:0]      rd_data,
    input  logic             wr_en,
    input  logic             wr_all,
    input  logic [ABITS-1:0] wr_addr,
    input  logic [15:0]      wr_data
);

    localparam int DEPTH = 1 << ABITS;

    logic [DEPTH*8-1:0] flat;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [ABITS-1:0] IDX = ABITS'(i);
        logic [7:0] cell_d, cell_q;
        logic       hit;

        always_comb begin
            if (wide) hit = wr_all || (wr_addr[ABITS-2:0] == IDX[ABITS-1:1]);
            else      hit = wr_all || (wr_addr == IDX);
            cell_d = cell_q;
            if (wr_en && hit) begin
                if (wide && IDX[0]) cell_d = wr_data[15:8];
                else                cell_d = wr_data[7:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= 8'hFF;
            else        cell_q <= cell_d;
        end

        assign flat[i*8 +: 8] = cell_q;
    end

    always_comb begin
        if (wide) rd_data = {flat[{rd_addr[ABITS-2:0], 1'b1}*8 +: 8],
                             flat[{rd_addr[ABITS-2:0], 1'b0}*8 +: 8]};
        else      rd_data = {8'h00, flat[rd_addr*8 +: 8]};
    end

endmodule

// File: rtl/mw_eeprom_core.sv
module mw_eeprom_core
    import mw_pkg::*;
#(
    parameter int ABITS       = 7,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic din,
    input  logic org,
    output logic dout,
    output logic dout_oe
);

    localparam int CMD_W = ABITS + 2;
    localparam int CNTW  = $clog2(CMD_W + 1);

    typedef struct packed {
        mw_state_e        st;
        logic [CMD_W-1:0] cmd;
        logic [CNTW-1:0]  cnt;
        logic [ABITS-1:0] addr;
        logic [3:0]       rbit;
        logic [15:0]      data;
        mw_prog_e         pend;
        logic             wen;
        logic             stat;
        logic             dout;
        logic             oe;
        logic             cs_prev;
        logic             sk_prev;
    } regs_t;

    regs_t r_d, r_q;

    logic [3:0] sync_w;
    logic       cs_s, sk_s, din_s, x16;

    mw_sync #(.WIDTH(4), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs, sk, din, org}),
        .sync_o  (sync_w)
    );
    assign {cs_s, sk_s, din_s, x16} = sync_w;

    logic busy, start;

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    logic             arr_we, arr_all;
    logic [15:0]      arr_wdata, rd_data;

    mw_store #(.ABITS(ABITS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide    (x16),
        .rd_addr (r_q.addr),
        .rd_data (rd_data),
        .wr_en   (arr_we),
        .wr_all  (arr_all),
        .wr_addr (r_q.addr),
        .wr_data (arr_wdata)
    );

    logic             sk_rise, cs_fall;
    logic [CMD_W-1:0] cmd_nx;
    logic [CNTW-1:0]  cmd_last;
    logic [1:0]       op, sub;
    logic [ABITS-1:0] dec_addr, next_addr;
    logic [3:0]       word_msb;

    always_comb begin
        sk_rise  = sk_s && !r_q.sk_prev;
        cs_fall  = !cs_s && r_q.cs_prev;
        cmd_nx   = {r_q.cmd[CMD_W-2:0], din_s};
        cmd_last = x16 ? CNTW'(CMD_W - 2) : CNTW'(CMD_W - 1);
        word_msb = x16 ? 4'd15 : 4'd7;
        if (x16) begin
            op        = cmd_nx[CMD_W-2 -: 2];
            sub       = cmd_nx[ABITS-2 -: 2];
            dec_addr  = {1'b0, cmd_nx[ABITS-2:0]};
            next_addr = {1'b0, r_q.addr[ABITS-2:0] + 1'b1};
        end else begin
            op        = cmd_nx[CMD_W-1 -: 2];
            sub       = cmd_nx[ABITS-1 -: 2];
            dec_addr  = cmd_nx[ABITS-1:0];
            next_addr = r_q.addr + 1'b1;
        end
    end

    always_comb begin
        r_d         = r_q;
        r_d.sk_prev = sk_s;
        r_d.cs_prev = cs_s;
        start       = 1'b0;
        arr_we      = 1'b0;
        arr_all     = 1'b0;
        arr_wdata   = 16'hFFFF;

        if (!cs_s) begin
            if (cs_fall && !busy && r_q.wen && (r_q.pend != PK_NONE)) begin
                start    = 1'b1;
                arr_we   = 1'b1;
                r_d.stat = 1'b1;
                unique case (r_q.pend)
                    PK_WRITE: arr_wdata = x16 ? r_q.data : {8'h00, r_q.data[7:0]};
                    PK_WRALL: begin
                        arr_all   = 1'b1;
                        arr_wdata = x16 ? r_q.data : {r_q.data[7:0], r_q.data[7:0]};
                    end
                    PK_ERAL:  arr_all = 1'b1;
                    default:  arr_wdata = 16'hFFFF;
                endcase
            end else if (!busy) begin
                r_d.stat = 1'b0;
            end
            r_d.st   = ST_IDLE;
            r_d.pend = PK_NONE;
        end else if (!busy && sk_rise) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (din_s) begin
                        r_d.st   = ST_CMD;
                        r_d.cmd  = '0;
                        r_d.cnt  = '0;
                        r_d.stat = 1'b0;
                    end
                end
                ST_CMD: begin
                    r_d.cmd = cmd_nx;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == cmd_last) begin
                        r_d.addr = dec_addr;
                        r_d.st   = ST_HOLD;
                        unique case (op)
                            OP_READ: begin
                                r_d.st   = ST_READ;
                                r_d.rbit = word_msb;
                                r_d.dout = 1'b0;
                            end
                            OP_WRITE: begin
                                r_d.st   = ST_DATA;
                                r_d.data = '0;
                                r_d.pend = PK_WRITE;
                            end
                            OP_ERASE: r_d.pend = PK_ERASE;
                            default: begin
                                unique case (sub)
                                    SUB_WEN: r_d.wen = 1'b1;
                                    SUB_WDS: r_d.wen = 1'b0;
                                    SUB_WRALL: begin
                                        r_d.st   = ST_DATA;
                                        r_d.data = '0;
                                        r_d.pend = PK_WRALL;
                                    end
                                    default: r_d.pend = PK_ERAL;
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: r_d.data = {r_q.data[14:0], din_s};
                ST_READ: begin
                    r_d.dout = rd_data[r_q.rbit];
                    if (r_q.rbit == 4'd0) begin
                        r_d.rbit = word_msb;
                        r_d.addr = next_addr;
                    end else begin
                        r_d.rbit = r_q.rbit - 1'b1;
                    end
                end
                default: r_d.st = r_q.st;
            endcase
        end

        if (cs_s && r_d.stat && (r_d.st != ST_READ)) r_d.dout = !busy;
        r_d.oe = cs_s && ((r_d.st == ST_READ) || r_d.stat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.pend <= PK_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout    = r_q.dout;
    assign dout_oe = r_q.oe;

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input logic      busy,
    input logic      wen_flag,
    input mw_state_e st,
    input logic      dout,
    input logic      dout_oe
);

    // R11: output released one clock after select is seen low
    p_oe_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !dout_oe);

    // R6: a programming cycle only begins with the latch set
    p_prog_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_flag));

    // R12: no command progress while the cycle runs
    p_busy_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st == ST_IDLE));

    // R4: first bit of every read is the dummy zero
    p_read_dummy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_READ) && ($past(st) != ST_READ)) |-> !dout);

    // R10: busy level is low on the output
    p_busy_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dout_oe && (st != ST_READ)) |-> !dout);

endmodule

bind mw_eeprom_core mw_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .busy     (busy),
    .wen_flag (r_q.wen),
    .st       (r_q.st),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/mw_eeprom_core_tb.sv
`timescale 1ns/1ps
module mw_eeprom_core_tb;

    localparam int PROG = 400;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, din = 1'b0, org = 1'b0;
    logic dout, dout_oe;

    always #2 clk = ~clk;

    mw_eeprom_core #(.ABITS(7), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .din(din),
        .org(org), .dout(dout), .dout_oe(dout_oe)
    );

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] mem_m [128];
    bit   wen_m = 0;
    logic s_dout, s_oe;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sk_cycle(logic b);
        din = b;
        repeat (HALF) @(negedge clk);
        sk = 1'b1;
        repeat (HALF) @(negedge clk);
        s_dout = dout;
        s_oe   = dout_oe;
        sk = 1'b0;
    endtask

    task automatic send(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) sk_cycle(v[i]);
    endtask

    task automatic cs_up();
        cs = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_down();
        cs = 1'b0; sk = 1'b0; din = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    function automatic int abits();
        return org ? 6 : 7;
    endfunction

    task automatic head(logic [1:0] op, logic [6:0] a);
        send({29'd0, 1'b1, op}, 3);
        send({25'd0, a}, abits());
    endtask

    task automatic wait_prog();
        repeat (PROG + 20) @(negedge clk);
    endtask

    task automatic set_wen(bit en);
        cs_up();
        head(2'b00, org ? {1'b0, en, en, 4'd0} : {en, en, 5'd0});
        cs_down();
        wen_m = en;
    endtask

    task automatic do_write(logic [6:0] a, logic [19:0] d, int nd);
        cs_up();
        head(2'b01, a);
        send({12'd0, d}, nd);
        cs_down();
        if (wen_m) begin
            if (org) begin
                mem_m[{a[5:0], 1'b0}] = d[7:0];
                mem_m[{a[5:0], 1'b1}] = d[15:8];
            end else mem_m[a] = d[7:0];
        end
    endtask

    function automatic logic [15:0] exp_at(logic [6:0] a);
        if (org) return {mem_m[{a[5:0], 1'b1}], mem_m[{a[5:0], 1'b0}]};
        return {8'h00, mem_m[a]};
    endfunction

    task automatic read_check(string tag, logic [6:0] a, int n);
        logic [6:0] p;
        logic [15:0] got;
        p = a;
        cs_up();
        head(2'b10, a);
        chk({tag, " R4 dummy oe"}, {15'd0, s_oe}, 16'd1);
        chk({tag, " R4 dummy bit"}, {15'd0, s_dout}, 16'd0);
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int b = (org ? 15 : 7); b >= 0; b--) begin
                sk_cycle(1'b0);
                got[b] = s_dout;
            end
            chk(tag, got, exp_at(p));
            p = org ? {1'b0, p[5:0] + 6'd1} : p + 7'd1;
        end
        cs_down();
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", {15'd0, dout_oe}, 16'd0);
        cs_up();
        repeat (4) @(negedge clk);
        chk("R1 oe with cs high idle", {15'd0, dout_oe}, 16'd0);
        cs_down();
        do_write(7'd5, 20'h00012, 8);
        wait_prog();
        read_check("R6 R1 write while disabled", 7'd5, 1);
    endtask

    task automatic t_status();
        set_wen(1);
        do_write(7'd5, 20'h000A5, 8);
        cs_up();
        chk("R10 status oe busy", {15'd0, dout_oe}, 16'd1);
        chk("R10 status busy level", {15'd0, dout}, 16'd0);
        repeat (PROG) @(negedge clk);
        chk("R10 status ready level", {15'd0, dout}, 16'd1);
        sk_cycle(1'b1);
        chk("R11 status cleared by start", {15'd0, s_oe}, 16'd0);
        cs_down();
        read_check("R7 x8 write", 7'd5, 1);
    endtask

    task automatic t_wide();
        org = 1'b1;
        repeat (4) @(negedge clk);
        do_write(7'd2, 20'hF1234, 20);
        wait_prog();
        read_check("R7 R3 x16 overlong", 7'd2, 1);
        org = 1'b0;
        repeat (4) @(negedge clk);
        read_check("R3 byte mapping", 7'd4, 2);
    endtask

    task automatic t_wrap();
        do_write(7'd126, 20'h0007E, 8); wait_prog();
        do_write(7'd127, 20'h0007F, 8); wait_prog();
        do_write(7'd0,   20'h00080, 8); wait_prog();
        read_check("R5 x8 wrap", 7'd126, 4);
        org = 1'b1;
        repeat (4) @(negedge clk);
        read_check("R5 x16 wrap", 7'd63, 2);
    endtask

    task automatic t_erase();
        cs_up(); head(2'b11, 7'd2); cs_down(); wait_prog();
        mem_m[4] = 8'hFF; mem_m[5] = 8'hFF;
        read_check("R8 erase word", 7'd2, 1);
        org = 1'b0;
        repeat (4) @(negedge clk);
        cs_up(); head(2'b00, 7'b1000000); cs_down(); wait_prog();
        for (int i = 0; i < 128; i++) mem_m[i] = 8'hFF;
        read_check("R8 erase all", 7'd125, 4);
    endtask

    task automatic t_fill();
        org = 1'b1;
        repeat (4) @(negedge clk);
        cs_up(); head(2'b00, 7'b0010000); send(32'hC3A5, 16); cs_down(); wait_prog();
        for (int i = 0; i < 128; i++) mem_m[i] = i[0] ? 8'hC3 : 8'hA5;
        read_check("R9 fill all", 7'd63, 2);
        org = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_busy();
        do_write(7'd10, 20'h0003C, 8);
        cs_up();
        send(32'b1000000000, 10);
        chk("R12 status during ignored cmd", {15'd0, s_oe}, 16'd1);
        chk("R12 busy level kept", {15'd0, s_dout}, 16'd0);
        cs_down();
        wait_prog();
        do_write(7'd11, 20'h00096, 8);
        wait_prog();
        read_check("R12 latch survives ignored cmd", 7'd10, 2);
    endtask

    task automatic t_abort();
        cs_up();
        send(32'b00100, 5);
        cs_down();
        cs_up();
        send(32'b00, 2);
        head(2'b01, 7'd12);
        send(32'h42, 8);
        cs_down();
        mem_m[12] = 8'h42;
        wait_prog();
        read_check("R13 R2 abort then write", 7'd12, 1);
    endtask

    task automatic t_late();
        do_write(7'd13, 20'h00011, 8);
        wait_prog();
        cs_up();
        chk("R11 no status after cycle", {15'd0, dout_oe}, 16'd0);
        cs_down();
        read_check("R7 late write", 7'd13, 1);
    endtask

    task automatic t_wds();
        set_wen(0);
        do_write(7'd14, 20'h00099, 8);
        wait_prog();
        read_check("R6 write after disable", 7'd14, 1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) mem_m[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_status();
        t_wide();
        t_wrap();
        t_erase();
        t_fill();
        t_busy();
        t_abort();
        t_late();
        t_wds();
        finish_run();
    end

endmodule